// File: doc/BRIEF.md
# Quadrature Position Counter with Single-Edge Cycle Counting

This block turns the two square-wave phase signals of an incremental encoder, plus its once-per-range marker line, into a binary position word. Both phases and the marker come in asynchronous to the system clock and are resynchronized first. The cycle counter changes at exactly one place in each quadrature cycle: where phase A toggles while phase B is low. Stepping forward across that point counts up. Stepping back across the same point counts down. A shaft that wobbles around that spot therefore leaves the count where it was, and never accumulates extra steps.

The position word is the cycle counter with two more bits appended below it. These two low bits are the current phase state turned into binary, with bit 1 taken from A and bit 0 equal to A XOR B. The result is a count with a resolution of one quarter cycle. It stays coherent because the counter steps exactly when the low bits wrap between 3 and 0.

A rising edge on the marker line loads the counter from a preset input. The preset is usually zero, but it can be any value, so distance-coded markers can seat the count at a known nonzero position. The block also gives one-clock up and down pulses for use by other logic.

Top module: `qpc_top`

## Requirements
- R1: After reset, `position` is 0 and `up_pulse`/`dn_pulse` are low. No count occurs until the synchronizer pipeline has been refilled, even if the phases are not 00 while reset is applied.
- R2: `position[1]` equals the synchronized A, and `position[0]` equals A XOR B. The forward phase order (A,B) is 00, 01, 11, 10, which gives low bits 0, 1, 2, 3.
- R3: When A goes from 1 to 0 with B low before and after (low bits 3 to 0), the counter field `position[W+1:2]` increments by one and `up_pulse` is high for exactly one clock.
- R4: When A goes from 0 to 1 with B low before and after (low bits 0 to 3), the counter field decrements by one and `dn_pulse` is high for exactly one clock.
- R5: Any other phase change, including a change of B or a change of A while B is high, leaves the counter unchanged and produces no pulse.
- R6: Back-and-forth movement across the 3/0 boundary returns the counter to its starting value. Each crossing counts exactly once.
- R7: The counter wraps modulo 2^W. Counting up from all ones gives 0, and counting down from 0 gives all ones.
- R8: A 0-to-1 edge on the synchronized marker line loads `preset` into the counter. If this edge falls in the same cycle as a count event, the load wins and no pulse is issued.
- R9: `up_pulse` and `dn_pulse` are never high together, and neither is ever high on two consecutive clocks.
- R10: A change on the inputs affects `position` and the pulses on the third rising clock edge after the change. That is two synchronizer stages followed by one update register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Phase A, asynchronous |
| enc_b | input | 1 | Phase B, asynchronous |
| enc_z | input | 1 | Marker (index) line, asynchronous |
| preset | input | W | Value loaded into the counter on a marker edge |
| position | output | W+2 | Counter bits above two phase-derived low bits |
| up_pulse | output | 1 | One-clock pulse on each forward count |
| dn_pulse | output | 1 | One-clock pulse on each reverse count |

## Verification
The hardest conditions to reach from the ports are a marker edge that lands in exactly the same cycle as a counting A edge, and a reset applied while the phases are not 00. The first needs both lines to change in the same clock, so that they pass through the equal-length synchronizers together. The second needs the phases held at 10 across reset release. Both are driven as directed cases. A random walk over legal and occasional illegal (two-step) phase jumps covers the rest, with random marker edges and preset values mixed in. A long 3/0 dither sequence then shows that the net count comes back to its starting value.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    typedef struct packed {
        logic a;
        logic b;
    } phase_t;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_UP   = 2'd1,
        EV_DOWN = 2'd2
    } step_e;

    // Gray-coded phase pair to a two-bit binary quarter index
    function automatic logic [1:0] phase_to_bin(phase_t s);
        return {s.a, s.a ^ s.b};
    endfunction

    // Counting point: A toggles while B is low on both samples
    function automatic step_e classify(phase_t prev, phase_t cur);
        step_e r;
        r = EV_NONE;
        if (!prev.b && !cur.b) begin
            if (prev.a && !cur.a)
                r = EV_UP;
            else if (!prev.a && cur.a)
                r = EV_DOWN;
        end
        return r;
    endfunction

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst)
                    chain <= '0;
                else
                    chain <= {chain[STAGES-2:0], d[i]};
            end
            assign q[i] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/qpc_edge.sv
module qpc_edge
    import qpc_pkg::*;
#(
    parameter int WARM = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_t cur,
    input  logic   z_cur,
    output phase_t held,
    output step_e  evt,
    output logic   idx_rise
);
    localparam int FW = $clog2(WARM + 1);

    logic [FW-1:0] fill;
    logic          armed;
    logic          z_q;

    assign armed = (fill == FW'(WARM));

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= '0;
            held <= '0;
            z_q  <= 1'b0;
        end else begin
            if (!armed)
                fill <= fill + FW'(1);
            held <= cur;
            z_q  <= z_cur;
        end
    end

    assign evt      = armed ? classify(held, cur) : EV_NONE;
    assign idx_rise = armed && z_cur && !z_q;

    AST_B_HIGH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cur.b || held.b) |-> (evt == EV_NONE)); // R5

    AST_NO_EVT_ON_STILL_A: assert property (@(posedge clk) disable iff (rst)
        (cur.a == held.a) |-> (evt == EV_NONE)); // R5
endmodule

// File: rtl/qpc_counter.sv
module qpc_counter
    import qpc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  step_e        evt,
    input  logic         load,
    input  logic [W-1:0] preset,
    output logic [W-1:0] cnt,
    output logic         up_q,
    output logic         dn_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
            if (load) begin
                cnt <= preset;
            end else begin
                case (evt)
                    EV_UP: begin
                        cnt  <= cnt + W'(1);
                        up_q <= 1'b1;
                    end
                    EV_DOWN: begin
                        cnt  <= cnt - W'(1);
                        dn_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        up_q |-> (cnt == $past(cnt) + W'(1))); // R3

    AST_DN_STEP: assert property (@(posedge clk) disable iff (rst)
        dn_q |-> (cnt == $past(cnt) - W'(1))); // R4

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(preset) && !up_q && !dn_q)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && evt == EV_NONE) |=> $stable(cnt)); // R5

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(up_q && dn_q)); // R9

    AST_UP_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        up_q |=> !up_q); // R9
endmodule

// File: rtl/qpc_top.sv
module qpc_top
    import qpc_pkg::*;
#(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enc_a,
    input  logic         enc_b,
    input  logic         enc_z,
    input  logic [W-1:0] preset,
    output logic [W+1:0] position,
    output logic         up_pulse,
    output logic         dn_pulse
);
    localparam int WARM = STAGES + 1;

    logic [2:0]   raw;
    logic [2:0]   syn;
    phase_t       cur;
    phase_t       held;
    step_e        evt;
    logic         idx_rise;
    logic [W-1:0] cnt;

    assign raw = {enc_z, enc_a, enc_b};

    qpc_sync #(.N(3), .STAGES(STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    assign cur.a = syn[1];
    assign cur.b = syn[0];

    qpc_edge #(.WARM(WARM)) i_edge (
        .clk      (clk),
        .rst      (rst),
        .cur      (cur),
        .z_cur    (syn[2]),
        .held     (held),
        .evt      (evt),
        .idx_rise (idx_rise)
    );

    qpc_counter #(.W(W)) i_cnt (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .load   (idx_rise),
        .preset (preset),
        .cnt    (cnt),
        .up_q   (up_pulse),
        .dn_q   (dn_pulse)
    );

    assign position = {cnt, phase_to_bin(held)};

    AST_LOW_BITS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (position[1:0] == {$past(cur.a), $past(cur.a) ^ $past(cur.b)})); // R2

    AST_DN_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        dn_pulse |=> !dn_pulse); // R9
endmodule

// File: tb/test_qpc_top.sv
module test_qpc_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         enc_a = 1'b1;
    logic         enc_b = 1'b0;
    logic         enc_z = 1'b0;
    logic [W-1:0] preset = '0;
    logic [W+1:0] position;
    logic         up_pulse;
    logic         dn_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int up_seen = 0;
    int dn_seen = 0;
    int cyc = 0;
    logic prev_up = 1'b0;
    logic prev_dn = 1'b0;

    // bench model
    logic         ma = 1'b1, mb = 1'b0, mz = 1'b0;
    logic [W-1:0] mcnt = '0;

    always #5 clk = ~clk;

    qpc_top #(.W(W)) i_qpc_top (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
        .preset(preset), .position(position), .up_pulse(up_pulse), .dn_pulse(dn_pulse)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // pulse monitor, sampled on falling edges
    always @(negedge clk) begin
        if (!rst) begin
            if (up_pulse) up_seen++;
            if (dn_pulse) dn_seen++;
            if (up_pulse && dn_pulse) begin
                n_chk++; n_bad++;
                $display("FAIL R9 actual=both_high expected=exclusive");
            end
            if ((up_pulse && prev_up) || (dn_pulse && prev_dn)) begin
                n_chk++; n_bad++;
                $display("FAIL R9 actual=two_clock_pulse expected=one_clock");
            end
        end
        prev_up = up_pulse;
        prev_dn = dn_pulse;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    function automatic logic [1:0] g2ab(input int g);
        case (g & 3)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    // drive one input change, let it settle, compare with the model
    task automatic step(input logic na, input logic nb, input logic nz, input string tag);
        int eu, ed;
        eu = 0; ed = 0;
        if (nz && !mz) mcnt = preset;
        else if (!mb && !nb && ma && !na) begin mcnt = mcnt + 1'b1; eu = 1; end
        else if (!mb && !nb && !ma && na) begin mcnt = mcnt - 1'b1; ed = 1; end
        ma = na; mb = nb; mz = nz;
        @(negedge clk);
        up_seen = 0; dn_seen = 0;
        enc_a = na; enc_b = nb; enc_z = nz;
        repeat (4) @(negedge clk);
        check({tag, " position"}, position, {mcnt, na, na ^ nb});
        check({tag, " up"}, up_seen, eu);
        check({tag, " down"}, dn_seen, ed);
    endtask

    task automatic go(input int g, input string tag);
        logic [1:0] s;
        s = g2ab(g);
        step(s[1], s[0], mz, tag);
    endtask

    initial begin
        int g;
        logic [W-1:0] start;
        // R1: reset with phases held at 10 (low bits 3)
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 pulses during reset", up_pulse | dn_pulse, 0);
        repeat (6) @(negedge clk);
        check("R1 no count after reset with nonzero phase", position, 10'h003);
        check("R1 no pulse after reset", up_seen + dn_seen, 0);

        // R10: exact latency of a forward count 3 -> 0
        @(negedge clk);
        up_seen = 0;
        enc_a = 1'b0; ma = 1'b0; mcnt = mcnt + 1'b1;
        repeat (2) @(negedge clk);
        check("R10 unchanged after two edges", position, 10'h003);
        @(negedge clk);
        check("R10 updated on third edge", position, 10'h004);
        check("R10 R3 up_pulse on third edge", up_pulse, 1);
        @(negedge clk);
        check("R3 pulse lasts one clock", up_pulse, 0);

        // R2/R5: walk forward through the quarter states
        go(1, "R2 R5 00->01");
        go(2, "R2 R5 01->11");
        go(3, "R2 R5 11->10");
        go(0, "R3 10->00");
        // R4 backwards
        go(3, "R4 00->10");
        go(2, "R5 10->11");
        go(3, "R5 11->10");

        // R6: dither across the counting point
        go(0, "R6 dither");
        start = mcnt;
        for (int k = 0; k < 10; k++) begin
            go(3, "R6 dither back");
            go(0, "R6 dither fwd");
        end
        check("R6 net count", position[W+1:2], start);

        // R8 + R7: load all ones via marker, then wrap up
        preset = '1;
        go(3, "R8 prep");
        step(1'b1, 1'b0, 1'b1, "R8 marker load");
        check("R8 loaded value", position[W+1:2], {W{1'b1}});
        step(1'b1, 1'b0, 1'b0, "R8 marker low");
        go(0, "R7 wrap up");
        check("R7 wrapped to zero", position[W+1:2], 0);
        go(3, "R7 wrap down");
        check("R7 wrapped to ones", position[W+1:2], {W{1'b1}});

        // R8 priority: marker edge in the same cycle as an up count
        preset = 8'h5A;
        step(1'b0, 1'b0, 1'b1, "R8 priority over count");
        check("R8 priority value", position[W+1:2], 8'h5A);
        step(1'b0, 1'b0, 1'b0, "R8 marker release");

        // random walk
        void'($urandom(32'h1234_5678));
        g = 0;
        for (int k = 0; k < 300; k++) begin
            int r;
            logic [1:0] s;
            logic nz;
            r = $urandom_range(0, 9);
            if (r < 5) g = g + 1;
            else if (r < 9) g = g + 3;
            else g = g + 2;
            s = g2ab(g);
            nz = ($urandom_range(0, 15) == 0);
            if (nz) preset = W'($urandom);
            step(s[1], s[0], nz, "R3 R4 R5 R8 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule